// File: doc/BRIEF.md
# Byte-Wide SPI Port with Master Fault Detection

This block is a single-byte serial peripheral interface that works either as the bus master, generating the serial clock itself, or as a slave clocked from outside. Software reaches it through three small registers: control, status and data. Writing the data register as master launches one eight-bit exchange. Bytes go out and come in most significant bit first. Clock polarity and phase are set by control bits. The master clock is the system clock divided by a power of two picked from a three-bit code.

The slave-select input has two jobs. In slave mode it qualifies the port: the port takes part in a transfer only while the input is low, and its serial output enable is released otherwise. In master mode a low level on the same input means another master has claimed the bus. The block then raises a sticky fault flag, leaves master mode, stops driving the clock and data lines, and abandons any transfer in progress. A select-ignore control bit switches this input off in two cases. For a master, the fault can no longer occur. For a slave in phase-1 timing, the port behaves as always selected. With phase-0 timing the bit is disregarded, because there the falling select is what frames the byte.

The register port has no back-pressure. Every access completes in the cycle it is presented, and the master accepts or ignores a data write at once, with no stall.

Top module: `spi_mfd_port`

## Requirements
- R1: In master mode the serial clock period equals the system clock divided by a factor chosen by control bits 6:4: code 0 gives 128, 1 gives 16, 2 gives 32, 3 gives 4, 4 gives 64 and 5 gives 8.
- R2: Rate codes 6 and 7 are reserved. With either code, a data write in master mode starts nothing: the serial clock stays at its idle level and the done flag stays clear.
- R3: In master mode a data write starts an eight-bit exchange. The byte is sent on the serial output MSB first, and the eight bits sampled from the serial input become the data register value. CPOL (control bit 1) is the idle clock level. CPHA (control bit 2) set to 0 samples on the leading clock edge and changes data on the trailing edge; set to 1, it does the reverse.
- R4: A data write made while a master exchange is under way is ignored, and the byte being sent is not disturbed.
- R5: Status bit 7 (done) sets after eight serial clock cycles. A data read alone leaves it set. A status read that sees it set, followed by a data read, clears it.
- R6: The serial output enable of a slave is asserted only while the port is in slave mode and selected. With select low it is asserted; with select high it is released.
- R7: In slave mode the port sends its data register MSB first and captures eight bits from the master on the externally supplied clock, obeying the same CPOL and CPHA rules as R3. Done sets at the end.
- R8: In master mode (control bit 0) with select-ignore (control bit 3) clear, a low select sets status bit 4 (fault). The block clears control bit 0, releases clock and data output enables, and abandons the exchange without setting done.
- R9: In master mode with select-ignore set, a low select never sets the fault flag, and exchanges complete normally.
- R10: The fault flag is sticky. Changing select-ignore does not clear it. Writing the status register (address 1) with bit 4 set clears it.
- R11: In slave mode with CPHA=1 and select-ignore set, the port acts as selected even with select high. With CPHA=0 the select-ignore bit has no effect, and a high select keeps the port out of any transfer.
- R12: Register addresses are 0 for control, 1 for status and 2 for data. Control holds master at bit 0, CPOL at bit 1, CPHA at bit 2, select-ignore at bit 3 and rate at bits 6:4. Status holds fault at bit 4 and done at bit 7. Reset clears every register and flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on status/data) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from address |
| ss_n_i | input | 1 | Slave-select input, active low |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data input (slave mode) |
| mosi_o | output | 1 | Master-out data output |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Slave-out data input (master mode) |
| miso_o | output | 1 | Slave-out data output |
| miso_oe | output | 1 | Slave-out output enable for tri-stating |

## Verification
Master exchanges run under all four polarity and phase combinations and all six valid rate codes. Each uses a different transmit and receive byte pair, with asymmetric patterns such as A5 against 3C, so a swapped bit order, a wrong sampling edge or a wrong divider each shows up as a distinct mismatch. Slave exchanges cover phase 0 framed by select, phase 1 framed by select, and phase 1 with the select pin held high under select-ignore. This separates correct qualification from a port that ignores select altogether. Fault scenarios assert select in the middle of a slow exchange, with select-ignore both clear and set, which shows whether the abort and the stickiness rules act on the right conditions.

// File: rtl/spi_mfd_pkg.sv
package spi_mfd_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int RATE_W = 3;
  localparam int HALF_W = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int STAT_FAULT_BIT = 4;
  localparam int STAT_DONE_BIT  = 7;

  // packed layout: rate[6:4] ss_ignore[3] cpha[2] cpol[1] master[0]
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              ss_ignore;
    logic              cpha;
    logic              cpol;
    logic              master;
  } ctrl_t;

  // half of the serial clock period in system clocks; zero marks a reserved code
  function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      3'd0:    h = HALF_W'(64);
      3'd1:    h = HALF_W'(8);
      3'd2:    h = HALF_W'(16);
      3'd3:    h = HALF_W'(2);
      3'd4:    h = HALF_W'(32);
      3'd5:    h = HALF_W'(4);
      default: h = '0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/spi_mfd_rate.sv
module spi_mfd_rate
  import spi_mfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] code,
  output logic              tick,
  output logic              code_ok
);

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt;

  assign half    = half_period(code);
  assign code_ok = (half != '0);
  assign tick    = run && code_ok && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || !code_ok)  cnt <= '0;
    else if (tick)              cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R1: the smallest divider still leaves at least one idle cycle between ticks
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_mfd_sync.sv
module spi_mfd_sync #(
  parameter int           N      = 3,
  parameter int           STAGES = 2,
  parameter logic [N-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT[i]}};
      else        chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_mfd_shift.sv
module spi_mfd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         clear,
  input  logic         lead_ev,
  input  logic         trail_ev,
  input  logic         cpha,
  input  logic         in_bit,
  output logic [W-1:0] data_q,
  output logic         out_bit,
  output logic         done,
  output logic         idle
);

  localparam int EDGES = 2 * W;
  localparam int CW    = $clog2(EDGES);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          out_q;
  logic          cap_ev, drv_ev, any_ev;

  assign cap_ev = cpha ? trail_ev : lead_ev;
  assign drv_ev = cpha ? lead_ev  : trail_ev;
  assign any_ev = lead_ev | trail_ev;
  assign done   = any_ev && (cnt == CW'(EDGES - 1));
  assign idle   = (cnt == '0);
  assign data_q = shreg;
  assign out_bit = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (load) begin
      shreg <= load_data;
      cnt   <= '0;
      out_q <= load_data[W-1];
    end else if (clear) begin
      cnt   <= '0;
      out_q <= shreg[W-1];
    end else begin
      if (cap_ev) shreg <= {shreg[W-2:0], in_bit};
      if (drv_ev)                   out_q <= shreg[W-1];
      else if (!any_ev && cnt == '0) out_q <= shreg[W-1];
      if (any_ev) cnt <= (cnt == CW'(EDGES - 1)) ? '0 : cnt + 1'b1;
    end
  end

  // R5: the final edge of a byte is always a trailing one
  a_r5_done_on_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trail_ev);

  // R3: lead and trail events come from one clock line and never coincide
  a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_ev && trail_ev));

endmodule

// File: rtl/spi_mfd_port.sv
module spi_mfd_port
  import spi_mfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ss_n_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);

  ctrl_t ctrl;
  logic  fault, done_flag, stat_seen, busy, sck_q, sck_d;
  logic  ss_s, sck_s, mosi_s;
  logic  is_master, selected, slave_sel;
  logic  tick, code_ok;
  logic  m_lead, m_trail, s_edge, s_lead, s_trail, lead_ev, trail_ev;
  logic  wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  logic  fault_set, load, sh_clear, sh_done, sh_idle, sh_out, in_bit, xfer_busy;
  logic [DATA_W-1:0] sh_data;
  logic  unused_wdata;

  assign unused_wdata = bus_wdata[DATA_W-1];

  // ---- input synchronisation: {select, clock, data} ----
  spi_mfd_sync #(.N(3), .STAGES(2), .INIT(3'b100)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({ss_n_i, sck_i, mosi_i}),
    .synced ({ss_s, sck_s, mosi_s})
  );

  // ---- register decode ----
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign rd_data = bus_rd && (bus_addr == A_DATA);

  // ---- mode and select qualification ----
  assign is_master = ctrl.master;
  assign selected  = !ss_s || (ctrl.ss_ignore && ctrl.cpha);
  assign slave_sel = !is_master && selected;
  assign fault_set = is_master && !ctrl.ss_ignore && !ss_s;

  // ---- master clock generation ----
  spi_mfd_rate u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (is_master && busy),
    .code    (ctrl.rate),
    .tick    (tick),
    .code_ok (code_ok)
  );

  assign m_lead  = tick && (sck_q == ctrl.cpol);
  assign m_trail = tick && (sck_q != ctrl.cpol);

  // ---- slave clock edge detection ----
  assign s_edge  = slave_sel && (sck_s != sck_d);
  assign s_lead  = s_edge && (sck_s != ctrl.cpol);
  assign s_trail = s_edge && (sck_s == ctrl.cpol);

  assign lead_ev  = is_master ? m_lead  : s_lead;
  assign trail_ev = is_master ? m_trail : s_trail;
  assign in_bit   = is_master ? miso_i  : mosi_s;

  // ---- transfer start and abort ----
  assign xfer_busy = is_master ? busy : !sh_idle;
  assign load      = wr_data && !xfer_busy && (!is_master || code_ok);
  assign sh_clear  = fault_set || (!is_master && !selected);

  spi_mfd_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (bus_wdata),
    .clear     (sh_clear),
    .lead_ev   (lead_ev),
    .trail_ev  (trail_ev),
    .cpha      (ctrl.cpha),
    .in_bit    (in_bit),
    .data_q    (sh_data),
    .out_bit   (sh_out),
    .done      (sh_done),
    .idle      (sh_idle)
  );

  // ---- state ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      fault     <= 1'b0;
      done_flag <= 1'b0;
      stat_seen <= 1'b0;
      busy      <= 1'b0;
      sck_q     <= 1'b0;
      sck_d     <= 1'b0;
    end else begin
      sck_d <= sck_s;

      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[6:0]);
      if (fault_set) ctrl.master <= 1'b0;

      if (fault_set)                              fault <= 1'b1;
      else if (wr_stat && bus_wdata[STAT_FAULT_BIT]) fault <= 1'b0;

      if (fault_set || !is_master)     busy <= 1'b0;
      else if (load)                   busy <= 1'b1;
      else if (sh_done)                busy <= 1'b0;

      if (!busy)     sck_q <= ctrl.cpol;
      else if (tick) sck_q <= !sck_q;

      if (sh_done) begin
        done_flag <= 1'b1;
        stat_seen <= 1'b0;
      end else if (rd_data) begin
        if (stat_seen) done_flag <= 1'b0;
        stat_seen <= 1'b0;
      end else if (rd_stat && done_flag) begin
        stat_seen <= 1'b1;
      end
    end
  end

  // ---- read mux ----
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {1'b0, ctrl};
      A_STAT: begin
        bus_rdata[STAT_DONE_BIT]  = done_flag;
        bus_rdata[STAT_FAULT_BIT] = fault;
      end
      A_DATA: bus_rdata = sh_data;
      default: bus_rdata = '0;
    endcase
  end

  // ---- pins ----
  assign sck_o   = busy ? sck_q : ctrl.cpol;
  assign sck_oe  = is_master;
  assign mosi_o  = is_master ? sh_out : 1'b0;
  assign mosi_oe = is_master;
  assign miso_o  = slave_sel ? sh_out : 1'b0;
  assign miso_oe = slave_sel;

  // ---- assertions ----
  a_r8_fault_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> (!sck_oe && !mosi_oe && !busy && fault));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(wr_stat && bus_wdata[STAT_FAULT_BIT])) |=> fault);

  a_r9_ignored_select_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && ctrl.master && ctrl.ss_ignore) |=> !fault);

  a_r6_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !mosi_oe);

  a_r4_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_data));

  a_r5_done_latched: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> done_flag);

endmodule

// File: tb/tb_spi_mfd_port.sv
module tb_spi_mfd_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ss_n_i, sck_i, mosi_i, miso_i;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int nvec  = 0;
  int nfail = 0;

  localparam logic [1:0] CTRL = 2'd0, STAT = 2'd1, DATA = 2'd2;

  always #5 clk = ~clk;

  spi_mfd_port dut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master exchange against a bench slave model
  task automatic master_xfer(input logic cpol, input logic cpha, input logic ssign,
                             input logic [2:0] code, input int div,
                             input logic [7:0] tx, input logic [7:0] stx, input bit poke);
    logic [7:0] rx = '0;
    logic [7:0] rd;
    logic       prev;
    int edges = 0, bi = 0, cyc = 0, l1 = -1, l2 = -1;
    bit poked = 0;
    bus_write(CTRL, {1'b0, code, ssign, cpha, cpol, 1'b1});
    check("R3 idle clock level", sck_o, cpol);
    miso_i = stx[7];
    bus_write(DATA, tx);
    prev = sck_o;
    while (edges < 16 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (poke) begin
        if (edges == 5 && !poked) begin
          bus_wr = 1'b1; bus_addr = DATA; bus_wdata = ~tx; poked = 1;
        end else bus_wr = 1'b0;
      end
      if (sck_o != prev) begin
        prev = sck_o;
        if (sck_o != cpol) begin
          if (l1 < 0) l1 = cyc; else if (l2 < 0) l2 = cyc;
          if (!cpha) rx = {rx[6:0], mosi_o};
          else if (bi < 8) miso_i = stx[7-bi];
        end else begin
          if (!cpha) begin bi++; if (bi < 8) miso_i = stx[7-bi]; end
          else begin rx = {rx[6:0], mosi_o}; bi++; end
        end
        edges++;
      end
    end
    bus_wr = 1'b0;
    check("R3 sixteen clock edges", edges, 16);
    check(poke ? "R4 byte on line unchanged by busy write" : "R3 byte sent MSB first", rx, tx);
    check("R1 clock period", l2 - l1, div);
    wait_cyc(4);
    check("R3 clock back at idle", sck_o, cpol);
    bus_read(DATA, rd);
    check("R3 received byte", rd, stx);
    bus_read(STAT, rd);
    check("R5 done after data read alone", rd[7], 1);
    check(ssign ? "R9 no fault with select ignored" : "R8 no fault with select high", rd[4], 0);
    bus_read(DATA, rd);
    bus_read(STAT, rd);
    check("R5 done cleared by status then data", rd[7], 0);
  endtask

  // slave exchange: bench plays master with an 8-cycle half period
  task automatic slave_xfer(input logic cpol, input logic cpha, input logic ssign,
                            input bit use_ss, input logic [7:0] tx_cpu, input logic [7:0] tx_m);
    logic [7:0] rx = '0;
    logic [7:0] rd;
    ss_n_i = 1'b1; sck_i = cpol; mosi_i = 1'b0;
    wait_cyc(4);
    bus_write(CTRL, {1'b0, 3'd0, ssign, cpha, cpol, 1'b0});
    bus_write(DATA, tx_cpu);
    wait_cyc(4);
    if (use_ss) begin
      check("R6 slave output released with select high", miso_oe, 0);
      ss_n_i = 1'b0;
      wait_cyc(8);
      check("R6 slave output driven with select low", miso_oe, 1);
    end else begin
      check("R11 permanently selected in phase 1", miso_oe, 1);
    end
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = tx_m[7-i];
        wait_cyc(8);
        rx = {rx[6:0], miso_o};
        sck_i = ~cpol;
        wait_cyc(8);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = tx_m[7-i];
        wait_cyc(8);
        rx = {rx[6:0], miso_o};
        sck_i = cpol;
        wait_cyc(8);
      end
    end
    wait_cyc(8);
    check(use_ss ? "R7 slave sent byte" : "R11 slave sent byte", rx, tx_cpu);
    if (use_ss) begin
      ss_n_i = 1'b1;
      wait_cyc(6);
      check("R6 release after select high", miso_oe, 0);
    end
    bus_read(STAT, rd);
    check("R7 slave done set", rd[7], 1);
    bus_read(DATA, rd);
    check("R7 slave received byte", rd, tx_m);
    bus_read(STAT, rd);
    check("R5 done cleared after slave", rd[7], 0);
  endtask

  task automatic test_reset;
    logic [7:0] rd;
    bus_read(CTRL, rd);
    check("R12 control reset", rd, 0);
    bus_read(STAT, rd);
    check("R12 status reset", rd, 0);
    check("R12 clock enable reset", sck_oe, 0);
    check("R12 mosi enable reset", mosi_oe, 0);
    check("R6 miso enable reset", miso_oe, 0);
  endtask

  task automatic test_rates;
    master_xfer(1'b0, 1'b0, 1'b0, 3'd3, 4,   8'hA5, 8'h3C, 0);
    master_xfer(1'b1, 1'b0, 1'b0, 3'd5, 8,   8'h5A, 8'hC3, 0);
    master_xfer(1'b0, 1'b1, 1'b0, 3'd1, 16,  8'h01, 8'h80, 0);
    master_xfer(1'b1, 1'b1, 1'b0, 3'd2, 32,  8'hFF, 8'h00, 0);
    master_xfer(1'b0, 1'b0, 1'b0, 3'd4, 64,  8'h96, 8'h69, 0);
    master_xfer(1'b0, 1'b1, 1'b0, 3'd0, 128, 8'h7E, 8'hE7, 0);
  endtask

  task automatic test_busy_write;
    master_xfer(1'b0, 1'b0, 1'b0, 3'd3, 4, 8'hC5, 8'h5C, 1);
  endtask

  task automatic test_select_ignored_master;
    bus_write(CTRL, 8'h00);
    ss_n_i = 1'b0;
    wait_cyc(4);
    master_xfer(1'b0, 1'b1, 1'b1, 3'd3, 4, 8'h3A, 8'hA3, 0);
    ss_n_i = 1'b1;
    wait_cyc(4);
  endtask

  task automatic test_reserved;
    logic [7:0] rd;
    for (int c = 6; c < 8; c++) begin
      int toggles = 0;
      logic prev;
      bus_write(CTRL, {1'b0, 3'(c), 4'b0001});
      bus_write(DATA, 8'h55);
      prev = sck_o;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (sck_o != prev) toggles++;
        prev = sck_o;
      end
      check("R2 no clock with reserved code", toggles, 0);
      bus_read(STAT, rd);
      check("R2 no done with reserved code", rd[7], 0);
    end
  endtask

  task automatic test_fault;
    logic [7:0] rd;
    bus_write(CTRL, 8'h01);
    bus_write(DATA, 8'h99);
    wait_cyc(100);
    ss_n_i = 1'b0;
    wait_cyc(6);
    check("R8 clock enable released", sck_oe, 0);
    check("R8 mosi enable released", mosi_oe, 0);
    bus_read(STAT, rd);
    check("R8 fault set", rd[4], 1);
    bus_read(CTRL, rd);
    check("R8 master bit cleared", rd[0], 0);
    ss_n_i = 1'b1;
    wait_cyc(1200);
    bus_read(STAT, rd);
    check("R8 aborted exchange sets no done", rd[7], 0);
    bus_write(CTRL, 8'h08);
    bus_write(CTRL, 8'h00);
    bus_read(STAT, rd);
    check("R10 fault survives select-ignore change", rd[4], 1);
    bus_write(STAT, 8'h10);
    bus_read(STAT, rd);
    check("R10 fault cleared by status write", rd[4], 0);
  endtask

  task automatic test_phase0_ignore;
    logic [7:0] rd;
    ss_n_i = 1'b1; sck_i = 1'b0;
    wait_cyc(4);
    bus_write(CTRL, 8'h08);
    wait_cyc(4);
    check("R11 select-ignore has no effect in phase 0", miso_oe, 0);
    for (int i = 0; i < 16; i++) begin
      sck_i = ~sck_i;
      wait_cyc(8);
    end
    bus_read(STAT, rd);
    check("R11 no transfer in phase 0 with select high", rd[7], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R3: actual %0d expected %0d (run did not finish)", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    ss_n_i = 1'b1; sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    test_reset();
    test_rates();
    test_busy_write();
    test_select_ignored_master();
    test_reserved();
    test_fault();
    slave_xfer(1'b0, 1'b0, 1'b0, 1, 8'hB4, 8'h4B);
    slave_xfer(1'b1, 1'b1, 1'b0, 1, 8'h2D, 8'hD2);
    slave_xfer(1'b0, 1'b1, 1'b1, 0, 8'hE1, 8'h1E);
    test_phase0_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule